// File: doc/BRIEF.md
# Dual-Port Double-Rate Burst SRAM

This block is a synthesizable behavioural model of a synchronous SRAM with one port for reads and another for writes. Every transfer is a burst of two words. The two ports run at the same time, so in any cycle one read and one write may both be started.

Both halves of the input clock are modelled by a single clock that runs at twice the rate. An internal phase bit separates "K" edges from "K#" edges. The `k_edge` output is high during each half-period that ends in a K edge. A request is taken only on a K edge. There the select, the address and the first write word are latched. The second write word arrives on the following K# edge. Read words leave three half-cycles after the request, first the even word and then the odd one. They come with a data-valid flag and a complementary echo strobe pair.

Within a burst, the low word address bit selects the word: 0 for the first word and 1 for the second. The latched request address supplies the upper bits.

Top module: `qdr_burst_sram`

## Requirements
- R1: While reset is high, and after reset on every half-cycle that carries no read word, `dvalid` is 0 and `dout` is 0. During reset `k_edge` is 1 and `echo_p` is 0.
- R2: If `wr_sel_n` is 0 on a K edge, `din` on that edge is stored at word address {`wr_addr`,0}.
- R3: The `din` value on the K# edge that follows a write request is stored at word address {latched `wr_addr`,1}.
- R4: Bit i of `bw_n` guards byte lane i, which is `din[i*BYTE_W +: BYTE_W]`. A 1 on a given edge leaves that lane of that burst word unchanged. The mask of the K edge applies to the first word and the mask of the K# edge to the second.
- R5: After a read request on K edge n, `dout` shows word {`rd_addr`,0} after edge n+3 and word {`rd_addr`,1} after edge n+4.
- R6: `dvalid` is 1 after exactly those two edges for each read, and 0 otherwise.
- R7: A read and a write may be requested on the same K edge. Each acts independently. If both target the same burst address, the read returns the contents from before the write.
- R8: Read requests on consecutive K edges produce an unbroken stream of words on `dout`.
- R9: After each K# edge, `echo_p` is 1 and `echo_n` is 0. After each K edge, `echo_p` is 0 and `echo_n` is 1.
- R10: `k_edge` alternates on every edge. The first edge after reset is a K edge. Select inputs that are low on K# edges have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; its rising edges alternate between K and K# |
| rst | input | 1 | Synchronous active-high reset |
| k_edge | output | 1 | High when the next rising edge is a K edge |
| wr_sel_n | input | 1 | Active-low write request, sampled on K edges |
| wr_addr | input | AW | Burst address of the write |
| din | input | BYTE_W*NBYTES | Write data: first word on K, second word on K# |
| bw_n | input | NBYTES | Active-low byte-lane write enables |
| rd_sel_n | input | 1 | Active-low read request, sampled on K edges |
| rd_addr | input | AW | Burst address of the read |
| dout | output | BYTE_W*NBYTES | Read data, one word per half-cycle |
| dvalid | output | 1 | Marks the half-cycles that carry read data |
| echo_p | output | 1 | Echo strobe, high in the half-cycle of the first read word |
| echo_n | output | 1 | Complement of the echo strobe |

## Verification
The bound checker examines on every cycle the properties that depend only on timing. These are the exact read latency, the absence of a data-valid flag without a matching request, the pairing of the two burst words, the idle value of the data bus, the complementary echo pair and the alternation of the phase. Data content cannot be judged from the ports over time. Only the bench scenarios can show it, by comparing each word read against a bench-side memory model. That comparison covers byte masking in each half of the burst, the old-data result when a read and a write hit the same address together, gapless back-to-back reads and selects that are pulsed on K# edges and must be ignored.

// File: rtl/qdr_pkg.sv
package qdr_pkg;

    // Half-period identity of the double-rate clock
    typedef enum logic {
        PH_K  = 1'b0,   // next edge is the K edge
        PH_KN = 1'b1    // next edge is the K# edge
    } phase_e;

    localparam int DEF_AW     = 6;
    localparam int DEF_BYTE_W = 9;
    localparam int DEF_NBYTES = 2;

    function automatic phase_e next_phase(input phase_e p);
        return (p == PH_K) ? PH_KN : PH_K;
    endfunction

endpackage

// File: rtl/qdr_wr_port.sv
module qdr_wr_port
    import qdr_pkg::*;
#(
    parameter int AW     = DEF_AW,
    parameter int BYTE_W = DEF_BYTE_W,
    parameter int NBYTES = DEF_NBYTES,
    localparam int DW    = BYTE_W * NBYTES,
    localparam int MAW   = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              is_k,
    input  logic              wr_sel_n,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     din,
    input  logic [NBYTES-1:0] bw_n,
    output logic              we,
    output logic [MAW-1:0]    waddr,
    output logic [DW-1:0]     wdata,
    output logic [NBYTES-1:0] wmask_n
);

    logic          pend;
    logic [AW-1:0] wa_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            wa_q <= '0;
        end else if (is_k) begin
            pend <= ~wr_sel_n;
            wa_q <= wr_addr;
        end else begin
            pend <= 1'b0;
        end
    end

    always_comb begin
        if (is_k) begin
            we    = ~wr_sel_n;
            waddr = {wr_addr, 1'b0};
        end else begin
            we    = pend;
            waddr = {wa_q, 1'b1};
        end
        wdata   = din;
        wmask_n = bw_n;
    end

endmodule

// File: rtl/qdr_array.sv
module qdr_array
    import qdr_pkg::*;
#(
    parameter int AW     = DEF_AW,
    parameter int BYTE_W = DEF_BYTE_W,
    parameter int NBYTES = DEF_NBYTES,
    localparam int DW    = BYTE_W * NBYTES,
    localparam int MAW   = AW + 1,
    localparam int DEPTH = 1 << MAW
) (
    input  logic              clk,
    input  logic              we,
    input  logic [MAW-1:0]    waddr,
    input  logic [DW-1:0]     wdata,
    input  logic [NBYTES-1:0] wmask_n,
    input  logic [AW-1:0]     raddr,
    output logic [DW-1:0]     rword0,
    output logic [DW-1:0]     rword1
);

    // One storage array per byte lane, so each lane has its own writer
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && !wmask_n[g])
                lane_mem[waddr] <= wdata[g*BYTE_W +: BYTE_W];
        end

        assign rword0[g*BYTE_W +: BYTE_W] = lane_mem[{raddr, 1'b0}];
        assign rword1[g*BYTE_W +: BYTE_W] = lane_mem[{raddr, 1'b1}];
    end

endmodule

// File: rtl/qdr_rd_pipe.sv
module qdr_rd_pipe
    import qdr_pkg::*;
#(
    parameter int DW = DEF_BYTE_W * DEF_NBYTES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          is_k,
    input  logic          rd_sel_n,
    input  logic [DW-1:0] rword0,
    input  logic [DW-1:0] rword1,
    output logic [DW-1:0] dout,
    output logic          dvalid
);

    typedef struct packed {
        logic          v;
        logic [DW-1:0] w0;
        logic [DW-1:0] w1;
    } stage_t;

    stage_t s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1     <= '0;
            s2     <= '0;
            s3     <= '0;
            dout   <= '0;
            dvalid <= 1'b0;
        end else if (is_k) begin
            // K edge: capture both words now (old data), send second word
            s1     <= '{v: ~rd_sel_n, w0: rword0, w1: rword1};
            s3     <= s2;
            dout   <= s3.v ? s3.w1 : '0;
            dvalid <= s3.v;
        end else begin
            // K# edge: advance, send first word
            s2     <= s1;
            dout   <= s3.v ? s3.w0 : '0;
            dvalid <= s3.v;
        end
    end

endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
    import qdr_pkg::*;
#(
    parameter int AW     = DEF_AW,
    parameter int BYTE_W = DEF_BYTE_W,
    parameter int NBYTES = DEF_NBYTES,
    localparam int DW    = BYTE_W * NBYTES,
    localparam int MAW   = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    output logic              k_edge,
    input  logic              wr_sel_n,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     din,
    input  logic [NBYTES-1:0] bw_n,
    input  logic              rd_sel_n,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     dout,
    output logic              dvalid,
    output logic              echo_p,
    output logic              echo_n
);

    phase_e             ph;
    logic               is_k;
    logic               we;
    logic [MAW-1:0]     waddr;
    logic [DW-1:0]      wdata;
    logic [NBYTES-1:0]  wmask_n;
    logic [DW-1:0]      rword0, rword1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_K;
            echo_p <= 1'b0;
            echo_n <= 1'b1;
        end else begin
            ph     <= next_phase(ph);
            echo_p <= (ph == PH_KN);
            echo_n <= (ph == PH_K);
        end
    end

    assign is_k   = (ph == PH_K);
    assign k_edge = is_k;

    qdr_wr_port #(.AW(AW), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_wr (
        .clk(clk), .rst(rst), .is_k(is_k),
        .wr_sel_n(wr_sel_n), .wr_addr(wr_addr), .din(din), .bw_n(bw_n),
        .we(we), .waddr(waddr), .wdata(wdata), .wmask_n(wmask_n)
    );

    qdr_array #(.AW(AW), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_mem (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata), .wmask_n(wmask_n),
        .raddr(rd_addr), .rword0(rword0), .rword1(rword1)
    );

    qdr_rd_pipe #(.DW(DW)) u_rd (
        .clk(clk), .rst(rst), .is_k(is_k), .rd_sel_n(rd_sel_n),
        .rword0(rword0), .rword1(rword1), .dout(dout), .dvalid(dvalid)
    );

endmodule

// File: rtl/qdr_burst_sram_chk.sv
module qdr_burst_sram_chk #(
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst,
    input logic          k_edge,
    input logic          rd_sel_n,
    input logic [DW-1:0] dout,
    input logic          dvalid,
    input logic          echo_p,
    input logic          echo_n
);

    a_r1_idle_bus_zero: assert property (@(posedge clk) disable iff (rst)
        !dvalid |-> (dout == '0));

    a_r5_read_latency: assert property (@(posedge clk) disable iff (rst)
        (k_edge && !rd_sel_n) |=> ##3 dvalid);

    a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        (k_edge && rd_sel_n) |=> ##3 !dvalid);

    a_r6_words_paired: assert property (@(posedge clk) disable iff (rst)
        (dvalid && echo_p) |=> dvalid);

    a_r9_echo_complement: assert property (@(posedge clk) disable iff (rst)
        echo_n == !echo_p);

    a_r9_echo_marks_first: assert property (@(posedge clk) disable iff (rst)
        $rose(dvalid) |-> echo_p);

    a_r10_phase_toggles: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (k_edge != $past(k_edge)));

endmodule

bind qdr_burst_sram qdr_burst_sram_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .k_edge(k_edge), .rd_sel_n(rd_sel_n),
    .dout(dout), .dvalid(dvalid), .echo_p(echo_p), .echo_n(echo_n)
);

// File: tb/tb_qdr_burst_sram.sv
module tb_qdr_burst_sram;

    localparam int CLK_P  = 10;
    localparam int AW     = 6;
    localparam int BYTE_W = 9;
    localparam int NB     = 2;
    localparam int DW     = BYTE_W * NB;
    localparam int NEXP   = 4096;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          k_edge;
    logic          wr_sel_n = 1'b1;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] din = '0;
    logic [NB-1:0] bw_n = '1;
    logic          rd_sel_n = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] dout;
    logic          dvalid;
    logic          echo_p, echo_n;

    int checks = 0;
    int errors = 0;
    int ecnt = 0;
    bit done = 0;

    logic [DW-1:0] model [1 << (AW + 1)];
    bit            exp_v [NEXP];
    logic [DW-1:0] exp_d [NEXP];
    string         exp_t [NEXP];

    always #(CLK_P / 2) clk = ~clk;

    qdr_burst_sram #(.AW(AW), .BYTE_W(BYTE_W), .NBYTES(NB)) dut (
        .clk(clk), .rst(rst), .k_edge(k_edge),
        .wr_sel_n(wr_sel_n), .wr_addr(wr_addr), .din(din), .bw_n(bw_n),
        .rd_sel_n(rd_sel_n), .rd_addr(rd_addr),
        .dout(dout), .dvalid(dvalid), .echo_p(echo_p), .echo_n(echo_n)
    );

    always @(posedge clk) ecnt <= rst ? 0 : ecnt + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h (edge %0d)", req, what, act, expv, ecnt);
        end
    endtask

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                            input logic [DW-1:0] nw,
                                            input logic [NB-1:0] m);
        logic [DW-1:0] r = old;
        for (int i = 0; i < NB; i++)
            if (!m[i]) r[i*BYTE_W +: BYTE_W] = nw[i*BYTE_W +: BYTE_W];
        return r;
    endfunction

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst && ecnt > 0 && ecnt < NEXP && !done) begin
            check(dvalid == exp_v[ecnt], "R6", "dvalid", DW'(dvalid), DW'(exp_v[ecnt]));
            if (exp_v[ecnt])
                check(dout == exp_d[ecnt], exp_t[ecnt], "dout", dout, exp_d[ecnt]);
            else
                check(dout == '0, "R1", "idle dout", dout, '0);
            check(echo_p == (ecnt % 2 == 0), "R9", "echo_p", DW'(echo_p), DW'(ecnt % 2 == 0));
            check(echo_n == (ecnt % 2 == 1), "R9", "echo_n", DW'(echo_n), DW'(ecnt % 2 == 1));
            check(k_edge == (ecnt % 2 == 0), "R10", "k_edge", DW'(k_edge), DW'(ecnt % 2 == 0));
        end
    end

    // One K cycle: request on the K edge, second write word on the K# edge
    task automatic kcycle(input bit wr, input logic [AW-1:0] wa,
                          input logic [DW-1:0] d0, input logic [NB-1:0] m0,
                          input logic [DW-1:0] d1, input logic [NB-1:0] m1,
                          input bit rd, input logic [AW-1:0] ra,
                          input string tag, input bit noise);
        int n;
        @(negedge clk);
        while (!k_edge) @(negedge clk);
        n = ecnt + 1;
        wr_sel_n = !wr; wr_addr = wa; din = d0; bw_n = m0;
        rd_sel_n = !rd; rd_addr = ra;
        if (rd && n + 4 < NEXP) begin
            exp_v[n + 3] = 1; exp_d[n + 3] = model[{ra, 1'b0}]; exp_t[n + 3] = tag;
            exp_v[n + 4] = 1; exp_d[n + 4] = model[{ra, 1'b1}]; exp_t[n + 4] = tag;
        end
        if (wr) begin
            model[{wa, 1'b0}] = merge(model[{wa, 1'b0}], d0, m0);
            model[{wa, 1'b1}] = merge(model[{wa, 1'b1}], d1, m1);
        end
        @(negedge clk);
        din = d1; bw_n = m1;
        // R10: selects pulsed on K# edges must change nothing
        wr_sel_n = !noise; rd_sel_n = !noise;
        wr_addr = AW'($urandom); rd_addr = AW'($urandom);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) kcycle(0, '0, '0, '1, '0, '1, 0, '0, "R6", 0);
    endtask

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < NEXP; i++) begin exp_v[i] = 0; exp_d[i] = '0; exp_t[i] = ""; end
        for (int i = 0; i < (1 << (AW + 1)); i++) model[i] = '0;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(dvalid == 1'b0, "R1", "reset dvalid", DW'(dvalid), '0);
        check(dout == '0, "R1", "reset dout", dout, '0);
        check(k_edge == 1'b1, "R1", "reset k_edge", DW'(k_edge), 1);
        check(echo_p == 1'b0, "R1", "reset echo_p", DW'(echo_p), '0);
        rst = 1'b0;

        // R2, R3: fill every burst address with both words, full mask
        for (int a = 0; a < (1 << AW); a++)
            kcycle(1, AW'(a), DW'($urandom), '0, DW'($urandom), '0, 0, '0, "R2", 0);
        for (int a = 0; a < 4; a++)
            kcycle(0, '0, '0, '1, '0, '1, 1, AW'(a), "R3", 0);

        // R4: lane masks differ between halves of the burst
        kcycle(1, 6'd5, 18'h3AAAA, 2'b01, 18'h15555, 2'b10, 0, '0, "R4", 0);
        kcycle(1, 6'd6, 18'h3FFFF, 2'b11, 18'h00000, 2'b00, 1, 6'd5, "R4", 0);
        kcycle(0, '0, '0, '1, '0, '1, 1, 6'd6, "R4", 0);

        // R7: same-cycle read and write to one address returns old data
        kcycle(1, 6'd9, 18'h12345, 2'b00, 18'h0ABCD, 2'b00, 1, 6'd9, "R7", 0);
        kcycle(1, 6'd3, 18'h11111, 2'b00, 18'h22222, 2'b00, 1, 6'd9, "R7", 0);
        idle(3);

        // R8: back-to-back reads stream without gaps
        for (int i = 0; i < 8; i++)
            kcycle(0, '0, '0, '1, '0, '1, 1, AW'(i + 10), "R8", 0);
        idle(3);

        // R5, R10: random concurrent traffic on a small address window
        for (int i = 0; i < 300; i++) begin
            kcycle(($urandom % 3) != 0, AW'($urandom % 8), DW'($urandom), NB'($urandom),
                   DW'($urandom), NB'($urandom), ($urandom % 3) != 0,
                   AW'($urandom % 8), "R5", ($urandom % 4) == 0);
        end
        idle(4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule